// File: doc/BRIEF.md
# Full-Bridge Gate Control Sequencer

This block is the clocked control core of a driver for an H-bridge built from four N-channel switches. Its inputs are a bridge-direction bit, a high-side enable, a shutdown request and an undervoltage flag. The direction bit is the already digitized result of an external comparator. The block drives four gate commands: upper and lower switch of leg A, and upper and lower switch of leg B. Each input first passes through a two-flop synchronizer.

Any output turns off in the same cycle in which its synchronized condition goes away. Turning an output on needs a run of consecutive cycles with its request held, and that run prevents shoot-through. The upper switches use one delay count and the lower switches use a separate count. When the high-side enable is low, both upper switches are held off and the lower switches keep following the direction bit, so the load current can freewheel through the bottom of the bridge.

Shutdown and undervoltage both force every output off. The same happens during reset. When shutdown, undervoltage or reset is released, a controller moves through four named states: `ST_OFF`, `ST_REFRESH`, `ST_WAIT_UPPER` and `ST_RUN`. In `ST_REFRESH` both lower switches are requested on so that the bootstrap capacitors recharge. In `ST_WAIT_UPPER` the lower switches follow the direction bit and the upper switches stay blocked. `ST_RUN` is normal operation.

The transitions are:
- `ST_OFF` → `ST_REFRESH` when the halt condition clears.
- `ST_REFRESH` → `ST_WAIT_UPPER` after `REFRESH_CYC` cycles.
- `ST_WAIT_UPPER` → `ST_RUN` once `UPEN_CYC` cycles have passed since the release.
- Any state → `ST_OFF` whenever shutdown or undervoltage is seen.

Top module: `bridge_gate_seq`

## Requirements
- R1: In `ST_RUN` with the enable high, direction 1 selects leg A upper plus leg B lower, and direction 0 selects leg B upper plus leg A lower. The switches that are not selected are off.
- R2: While the synchronized shutdown input is 1, all four outputs are 0, whatever the other inputs do.
- R3: While the synchronized undervoltage input is 1, all four outputs are 0, exactly as in R2.
- R4: While the synchronized enable is 0, both upper outputs are 0, and the lower outputs still follow the direction bit as in R1.
- R5: Every input takes effect two clock edges after it is sampled. An output drops in the same cycle in which its synchronized request is withdrawn, with no further delay.
- R6: An upper output rises only after its request has been sampled high at `HI_DLY`+1 consecutive edges.
- R7: A lower output rises only after its request has been sampled high at `LO_DLY`+1 consecutive edges.
- R8: After a release, the controller spends `REFRESH_CYC` cycles in `ST_REFRESH`, requesting both lower outputs and neither upper output. Both lower outputs are therefore high together for `REFRESH_CYC`-`LO_DLY`-1 cycles.
- R9: No upper output is high before `ST_RUN`. `ST_RUN` begins `UPEN_CYC` cycles after `ST_REFRESH` is entered.
- R10: If a request is withdrawn while its turn-on count is still pending, the count is cancelled. A direction pulse shorter than the delay therefore produces no turn-on.
- R11: The upper and lower outputs of one leg are never high in the same cycle.
- R12: During reset all outputs are 0. After reset is released, the R8 sequence runs before any upper output can turn on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_in | input | 1 | Bridge direction from the digitized comparator |
| hen_in | input | 1 | High-side enable; 0 forces the upper switches off |
| dis_in | input | 1 | Shutdown request; 1 forces all outputs off |
| uv_in | input | 1 | Undervoltage flag; 1 forces all outputs off |
| a_hi | output | 1 | Gate command, leg A upper switch |
| a_lo | output | 1 | Gate command, leg A lower switch |
| b_hi | output | 1 | Gate command, leg B upper switch |
| b_lo | output | 1 | Gate command, leg B lower switch |

## Verification
The assertions assume that the inputs are quasi-static relative to the clock and are consumed only after synchronization, so they are written against the synchronized copies of the inputs. They also assume that `UPEN_CYC` is larger than `REFRESH_CYC`. The stimulus changes inputs only at falling clock edges. It uses the default counts, in which the refresh window is shorter than the upper-enable wait. It holds every level long enough for each delay to expire, except in the deliberate short pulses that test R10. It also drops shutdown in the middle of a refresh and releases it again.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
    typedef enum logic [1:0] {
        ST_OFF        = 2'd0,
        ST_REFRESH    = 2'd1,
        ST_WAIT_UPPER = 2'd2,
        ST_RUN        = 2'd3
    } bgs_state_e;

    // bit positions inside the 4-bit gate vectors
    localparam int G_AHI = 3;
    localparam int G_ALO = 2;
    localparam int G_BHI = 1;
    localparam int G_BLO = 0;
    localparam int N_GATES = 4;
endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bgs_turnon.sv
module bgs_turnon #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic gate
);
    localparam int CW = $clog2(DLY + 2);
    localparam logic [CW-1:0] LIMIT = CW'(DLY);

    logic [CW-1:0] cnt;
    logic          done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!req) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == LIMIT) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // turn-off is immediate: the request gates the output directly
    assign gate = req & done;
endmodule

// File: rtl/bgs_ctrl.sv
module bgs_ctrl
    import bgs_pkg::*;
#(
    parameter int REFRESH_CYC = 48,
    parameter int UPEN_CYC    = 60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dir_s,
    input  logic                 hen_s,
    input  logic                 halt,
    output bgs_state_e           state,
    output logic [N_GATES-1:0]   req
);
    localparam int TW = $clog2(UPEN_CYC + 1);
    localparam logic [TW-1:0] REF_LAST = TW'(REFRESH_CYC - 1);
    localparam logic [TW-1:0] UP_LAST  = TW'(UPEN_CYC - 1);

    bgs_state_e    nxt;
    logic [TW-1:0] tmr;

    // state register and release timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            tmr   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_OFF || halt) begin
                tmr <= '0;
            end else if (state != ST_RUN) begin
                tmr <= tmr + 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:        if (!halt) nxt = ST_REFRESH;
            ST_REFRESH:    if (halt) nxt = ST_OFF;
                           else if (tmr == REF_LAST) nxt = ST_WAIT_UPPER;
            ST_WAIT_UPPER: if (halt) nxt = ST_OFF;
                           else if (tmr == UP_LAST) nxt = ST_RUN;
            ST_RUN:        if (halt) nxt = ST_OFF;
        endcase
    end

    // gate requests per state
    always_comb begin
        req = '0;
        unique case (state)
            ST_OFF: req = '0;
            ST_REFRESH: begin
                req[G_ALO] = 1'b1;
                req[G_BLO] = 1'b1;
            end
            ST_WAIT_UPPER: begin
                req[G_ALO] = !dir_s;
                req[G_BLO] = dir_s;
            end
            ST_RUN: begin
                req[G_AHI] = dir_s & hen_s;
                req[G_BLO] = dir_s;
                req[G_BHI] = !dir_s & hen_s;
                req[G_ALO] = !dir_s;
            end
        endcase
        if (halt) req = '0;
    end
endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
    import bgs_pkg::*;
#(
    parameter int HI_DLY      = 6,
    parameter int LO_DLY      = 4,
    parameter int REFRESH_CYC = 48,
    parameter int UPEN_CYC    = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_in,
    input  logic hen_in,
    input  logic dis_in,
    input  logic uv_in,
    output logic a_hi,
    output logic a_lo,
    output logic b_hi,
    output logic b_lo
);
    logic [3:0]         sync_q;
    logic               dir_s, hen_s, dis_s, uv_s;
    bgs_state_e         state;
    logic [N_GATES-1:0] req_v;
    logic [N_GATES-1:0] gate_v;

    // shutdown and undervoltage come out of reset asserted
    bgs_sync #(.W(4), .RST_VAL(4'b0011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({dir_in, hen_in, dis_in, uv_in}),
        .q    (sync_q)
    );
    assign {dir_s, hen_s, dis_s, uv_s} = sync_q;

    bgs_ctrl #(.REFRESH_CYC(REFRESH_CYC), .UPEN_CYC(UPEN_CYC)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .dir_s(dir_s),
        .hen_s(hen_s),
        .halt (dis_s | uv_s),
        .state(state),
        .req  (req_v)
    );

    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        localparam int D = (g == G_AHI || g == G_BHI) ? HI_DLY : LO_DLY;
        bgs_turnon #(.DLY(D)) u_on (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req_v[g]),
            .gate (gate_v[g])
        );
    end

    assign a_hi = gate_v[G_AHI];
    assign a_lo = gate_v[G_ALO];
    assign b_hi = gate_v[G_BHI];
    assign b_lo = gate_v[G_BLO];
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker
    import bgs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       a_hi,
    input logic       a_lo,
    input logic       b_hi,
    input logic       b_lo,
    input logic       dir_s,
    input logic       hen_s,
    input logic       dis_s,
    input logic       uv_s,
    input bgs_state_e state
);
    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(a_hi && a_lo)); // R11
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(b_hi && b_lo)); // R11
    AST_DIS_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n) dis_s |-> !(a_hi || a_lo || b_hi || b_lo)); // R2
    AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n) uv_s |-> !(a_hi || a_lo || b_hi || b_lo)); // R3
    AST_HEN_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n) !hen_s |-> (!a_hi && !b_hi)); // R4
    AST_UPPER_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n) (a_hi || b_hi) |-> state == ST_RUN); // R9
    AST_REFRESH_NO_UPPER: assert property (@(posedge clk) disable iff (!rst_n) state == ST_REFRESH |-> (!a_hi && !b_hi)); // R8
    AST_A_HI_DIR: assert property (@(posedge clk) disable iff (!rst_n) a_hi |-> dir_s); // R1
    AST_B_HI_DIR: assert property (@(posedge clk) disable iff (!rst_n) b_hi |-> !dir_s); // R1
    AST_LO_OFF_ON_FLIP: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RUN && $rose(dir_s)) |-> !a_lo); // R5
endmodule

bind bridge_gate_seq bgs_checker u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .a_hi (a_hi),
    .a_lo (a_lo),
    .b_hi (b_hi),
    .b_lo (b_lo),
    .dir_s(dir_s),
    .hen_s(hen_s),
    .dis_s(dis_s),
    .uv_s (uv_s),
    .state(state)
);

// File: tb/tb_bridge_gate_seq.sv
`timescale 1ns/1ps
module tb_bridge_gate_seq;
    localparam int HI_DLY = 6;
    localparam int LO_DLY = 4;
    localparam int REF_C  = 48;
    localparam int UP_C   = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_in = 1'b1, hen_in = 1'b1, dis_in = 1'b0, uv_in = 1'b0;
    logic a_hi, a_lo, b_hi, b_lo;

    always #4 clk = ~clk; // 125 MHz

    bridge_gate_seq #(.HI_DLY(HI_DLY), .LO_DLY(LO_DLY), .REFRESH_CYC(REF_C), .UPEN_CYC(UP_C)) dut (
        .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .hen_in(hen_in), .dis_in(dis_in), .uv_in(uv_in),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R12";

    // behavioural reference: bit 3 AH, 2 AL, 1 BH, 0 BL; sync word {dir,hen,dis,uv}
    logic [3:0] m_s1 = 4'b0011, m_s2 = 4'b0011;
    int phase = 0;
    int t = 0;
    int run_cnt [4] = '{0, 0, 0, 0};

    function automatic logic [3:0] m_req(input int ph, input logic [3:0] s);
        logic [3:0] r;
        r = 4'b0000;
        if (s[1] || s[0]) return 4'b0000;
        if (ph == 1) r = 4'b0101;
        else if (ph == 2) r = s[3] ? 4'b0001 : 4'b0100;
        else if (ph == 3) begin
            if (s[3]) r = {s[2], 1'b0, 1'b0, 1'b1};
            else      r = {1'b0, 1'b1, s[2], 1'b0};
        end
        return r;
    endfunction

    function automatic int dly_of(input int i);
        return (i == 3 || i == 1) ? HI_DLY : LO_DLY;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 4'b0011; m_s2 = 4'b0011; phase = 0; t = 0;
            for (int i = 0; i < 4; i++) run_cnt[i] = 0;
        end else begin
            logic [3:0] r;
            r = m_req(phase, m_s2);
            for (int i = 0; i < 4; i++) begin
                if (!r[i]) run_cnt[i] = 0;
                else if (run_cnt[i] <= dly_of(i)) run_cnt[i]++;
            end
            if (m_s2[1] || m_s2[0]) begin
                phase = 0; t = 0;
            end else if (phase == 0) begin
                phase = 1; t = 0;
            end else if (phase == 1) begin
                t++; if (t == REF_C) phase = 2;
            end else if (phase == 2) begin
                t++; if (t == UP_C) phase = 3;
            end
            m_s2 = m_s1;
            m_s1 = {dir_in, hen_in, dis_in, uv_in};
        end
    end

    function automatic logic [3:0] m_out();
        logic [3:0] r, o;
        r = m_req(phase, m_s2);
        for (int i = 0; i < 4; i++) o[i] = r[i] && (run_cnt[i] > dly_of(i));
        return o;
    endfunction

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        logic [3:0] act, exp_v;
        act = {a_hi, a_lo, b_hi, b_lo};
        exp_v = m_out();
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: gates {AH,AL,BH,BL} actual %b expected %b at %0t", tag, act, exp_v, $time);
        end
        n_cmp++;
        if ((a_hi && a_lo) || (b_hi && b_lo)) begin
            n_bad++;
            $display("FAIL R11: leg overlap actual %b expected no overlap at %0t", act, $time);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_val(input string rq, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp_v);
        end
    endtask

    // release shutdown and measure refresh overlap and upper lockout
    task automatic release_and_measure(input string rq);
        int both;
        int first_hi;
        both = 0; first_hi = -1;
        @(negedge clk);
        dis_in = 1'b0;
        for (int i = 0; i < UP_C + 30; i++) begin
            @(negedge clk);
            #1;
            if (a_lo && b_lo) both++;
            if ((a_hi || b_hi) && first_hi < 0) first_hi = i;
        end
        check_val({rq, "/R8 refresh overlap"}, both, REF_C - LO_DLY - 1);
        n_cmp++;
        if (first_hi >= 0 && first_hi < UP_C) begin
            n_bad++;
            $display("FAIL R9: upper on after %0d cycles expected >= %0d", first_hi, UP_C);
        end
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                // R12: reset holds outputs low
                tag = "R12";
                wait_cyc(5);
                @(negedge clk); rst_n = 1'b1;
                tag = "R8";
                wait_cyc(UP_C + 20);
                // R1 R5 R6 R7: long direction holds
                tag = "R1";
                dir_in = 1'b0; wait_cyc(25);
                tag = "R6";
                dir_in = 1'b1; wait_cyc(25);
                tag = "R7";
                dir_in = 1'b0; wait_cyc(3); dir_in = 1'b1; wait_cyc(25);
                // R10: short pulses cancel pending turn-on
                tag = "R10";
                for (int k = 0; k < 4; k++) begin
                    dir_in = 1'b0; wait_cyc(2); dir_in = 1'b1; wait_cyc(2);
                end
                wait_cyc(20);
                // R4: chop, lows keep following direction
                tag = "R4";
                hen_in = 1'b0; wait_cyc(10);
                dir_in = 1'b0; wait_cyc(15); dir_in = 1'b1; wait_cyc(15);
                hen_in = 1'b1; wait_cyc(20);
                // R2: shutdown overrides
                tag = "R2";
                dis_in = 1'b1; wait_cyc(5);
                dir_in = 1'b0; wait_cyc(15);
                tag = "R8";
                release_and_measure("R2");
                // R3: undervoltage behaves the same
                tag = "R3";
                uv_in = 1'b1; wait_cyc(5); dir_in = 1'b1; wait_cyc(10);
                tag = "R9";
                uv_in = 1'b0; wait_cyc(UP_C + 25);
                // shutdown during refresh restarts the sequence
                tag = "R8";
                dis_in = 1'b1; wait_cyc(10); dis_in = 1'b0; wait_cyc(20);
                dis_in = 1'b1; wait_cyc(3);
                release_and_measure("R12");
                tag = "R1";
                dir_in = 1'b0; wait_cyc(20);
            end
            begin
                while (wd < 100000) begin @(posedge clk); wd++; end
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule